// File: doc/BRIEF.md
# GPIO External Interrupt Controller

This block turns up to 32 general-purpose input pins into interrupt sources. Each pin is first brought into the clock domain through a two-flop synchronizer. A per-line detector then compares the synchronized level with its value one clock earlier and raises an event according to the line's trigger mode. Each event latches a pending bit. Software reads the pending bits, clears them by writing ones, and chooses through an enable bank which pending lines drive the single interrupt output.

Software uses a plain single-cycle register port. A write takes effect at the clock edge where `wr_en_i` is high. A read is requested with `rd_en_i`, and the data appears on `rd_data_o` one clock later. `rd_data_o` holds that value until the next read. There are four trigger-configuration words, then an enable word, then a pending-status word. Each line's mode is a 4-bit field in the configuration words.

Top module: `gpio_eint_ctrl`

## Requirements
- R1: After reset, all configuration, enable and status registers read as zero and `irq_o` is low.
- R2: Configuration word k sits at byte address 0x200 + 4k (k = 0..3). Line n's 4-bit mode field is bits [(n mod 8)*4 +: 4] of word n/8. All 32 bits of each configuration word read back as written. The enable word is at 0x210 and the status word is at 0x214, with bit n belonging to line n.
- R3: Mode 0 sets the line's status bit on a synchronized low-to-high transition only.
- R4: Mode 1 sets the line's status bit on a synchronized high-to-low transition only.
- R5: Mode 4 sets the line's status bit on every synchronized transition in either direction.
- R6: Mode 2 (high) and mode 3 (low) set the status bit on every cycle the synchronized level matches. A clear therefore cannot take effect while the level stays active.
- R7: Mode values 5 to 15 never set a status bit, whatever the pin does.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When an event on a line coincides with a clear of that line's bit, the bit stays set.
- R9: Status bits latch events whether or not the line is enabled. `irq_o` is a register that, one clock after the fact, shows whether any line has both its status and enable bits set.
- R10: Reads from any address other than the six mapped words return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert |
| pin_i | input | LINES (32) | Asynchronous pin levels |
| addr_i | input | ADDR_W (12) | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe; data appears one cycle later |
| rd_data_o | output | 32 | Read data, held until the next read |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a clear that lands in the same cycle as a new edge event on the same line. The detector sees a pin change only after the two synchronizer flops. The bench therefore changes a pin at a falling clock edge and places the clearing write exactly two falling edges later, so the write is sampled on the same rising edge that would latch the event. Level modes exercise the same collision continuously: a held level keeps raising an event in every cycle, and the clear must lose to it.

// File: rtl/eint_pkg.sv
package eint_pkg;
    localparam int MODE_W        = 4;
    localparam int LINES_PER_CFG = 8;
    localparam int CFG_BASE      = 'h200;
    localparam int EN_ADDR       = 'h210;
    localparam int STAT_ADDR     = 'h214;

    typedef enum logic [MODE_W-1:0] {
        TRIG_RISE = 4'd0,
        TRIG_FALL = 4'd1,
        TRIG_HIGH = 4'd2,
        TRIG_LOW  = 4'd3,
        TRIG_BOTH = 4'd4
    } trig_e;
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            s_d.chain[s] = s_q.chain[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign sync_o = s_q.chain[STAGES-1];
endmodule

// File: rtl/eint_detect.sv
module eint_detect
    import eint_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [LINES-1:0]        lvl_i,
    input  logic [LINES*MODE_W-1:0] mode_i,
    output logic [LINES-1:0]        evt_o
);
    typedef struct packed {
        logic [LINES-1:0] prev;
    } det_t;

    det_t s_d, s_q;

    function automatic logic trig_hit(input logic [MODE_W-1:0] mode,
                                      input logic cur, input logic old);
        logic h;
        case (mode)
            TRIG_RISE: h = cur & ~old;
            TRIG_FALL: h = ~cur & old;
            TRIG_HIGH: h = cur;
            TRIG_LOW:  h = ~cur;
            TRIG_BOTH: h = cur ^ old;
            default:   h = 1'b0;
        endcase
        return h;
    endfunction

    always_comb begin
        s_d      = s_q;
        s_d.prev = lvl_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign evt_o[g] = trig_hit(mode_i[g*MODE_W +: MODE_W], lvl_i[g], s_q.prev[g]);
    end
endmodule

// File: rtl/eint_regs.sv
module eint_regs
    import eint_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int ADDR_W = 12
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    wr_en_i,
    input  logic [31:0]             wr_data_i,
    input  logic                    rd_en_i,
    input  logic [LINES-1:0]        evt_i,
    output logic [LINES*MODE_W-1:0] mode_o,
    output logic [LINES-1:0]        en_o,
    output logic [LINES-1:0]        stat_o,
    output logic [31:0]             rd_data_o,
    output logic                    irq_o
);
    localparam int NUM_CFG = LINES / LINES_PER_CFG;

    typedef struct packed {
        logic [NUM_CFG-1:0][31:0] cfg;
        logic [LINES-1:0]         en;
        logic [LINES-1:0]         stat;
        logic [31:0]              rd;
        logic                     irq;
    } rf_t;

    rf_t r_d, r_q;

    logic [NUM_CFG-1:0] hit_cfg;
    logic               hit_en;
    logic               hit_stat;

    always_comb begin
        for (int k = 0; k < NUM_CFG; k++) begin
            hit_cfg[k] = (addr_i == ADDR_W'(CFG_BASE + 4 * k));
        end
        hit_en   = (addr_i == ADDR_W'(EN_ADDR));
        hit_stat = (addr_i == ADDR_W'(STAT_ADDR));
    end

    always_comb begin
        logic [LINES-1:0] clr;
        logic [31:0]      mux;
        r_d = r_q;

        for (int k = 0; k < NUM_CFG; k++) begin
            if (wr_en_i && hit_cfg[k]) r_d.cfg[k] = wr_data_i;
        end
        if (wr_en_i && hit_en) r_d.en = wr_data_i[LINES-1:0];

        clr      = (wr_en_i && hit_stat) ? wr_data_i[LINES-1:0] : '0;
        r_d.stat = (r_q.stat & ~clr) | evt_i;

        r_d.irq  = |(r_q.stat & r_q.en);

        mux = '0;
        for (int k = 0; k < NUM_CFG; k++) begin
            if (hit_cfg[k]) mux = r_q.cfg[k];
        end
        if (hit_en)   mux = 32'(r_q.en);
        if (hit_stat) mux = 32'(r_q.stat);
        if (rd_en_i)  r_d.rd = mux;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign mode_o    = r_q.cfg;
    assign en_o      = r_q.en;
    assign stat_o    = r_q.stat;
    assign rd_data_o = r_q.rd;
    assign irq_o     = r_q.irq;
endmodule

// File: rtl/gpio_eint_ctrl.sv
module gpio_eint_ctrl
    import eint_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [LINES-1:0]  pin_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [31:0]       wr_data_i,
    input  logic              rd_en_i,
    output logic [31:0]       rd_data_o,
    output logic              irq_o
);
    logic [LINES-1:0]        lvl_w;
    logic [LINES-1:0]        evt_w;
    logic [LINES*MODE_W-1:0] mode_w;
    logic [LINES-1:0]        en_w;
    logic [LINES-1:0]        stat_w;

    eint_sync #(.W(LINES), .STAGES(2)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pin_i),
        .sync_o  (lvl_w)
    );

    eint_detect #(.LINES(LINES)) u_detect (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (lvl_w),
        .mode_i (mode_w),
        .evt_o  (evt_w)
    );

    eint_regs #(.LINES(LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_en_i   (rd_en_i),
        .evt_i     (evt_w),
        .mode_o    (mode_w),
        .en_o      (en_w),
        .stat_o    (stat_w),
        .rd_data_o (rd_data_o),
        .irq_o     (irq_o)
    );
endmodule

// File: rtl/eint_ctrl_chk.sv
module eint_ctrl_chk
    import eint_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int ADDR_W = 12
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic [ADDR_W-1:0]       addr_i,
    input logic                    wr_en_i,
    input logic [31:0]             wr_data_i,
    input logic                    rd_en_i,
    input logic [31:0]             rd_data_o,
    input logic                    irq_o,
    input logic [LINES-1:0]        evt_w,
    input logic [LINES*MODE_W-1:0] mode_w,
    input logic [LINES-1:0]        en_w,
    input logic [LINES-1:0]        stat_w
);
    logic mapped;
    always_comb begin
        mapped = (addr_i == ADDR_W'(EN_ADDR)) || (addr_i == ADDR_W'(STAT_ADDR));
        for (int k = 0; k < LINES / LINES_PER_CFG; k++) begin
            if (addr_i == ADDR_W'(CFG_BASE + 4 * k)) mapped = 1'b1;
        end
    end

    // R9
    irq_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == $past(|(stat_w & en_w)));

    // R8
    clear_applies_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == ADDR_W'(STAT_ADDR)) |=>
        ((stat_w & $past(wr_data_i[LINES-1:0]) & ~$past(evt_w)) == '0));

    // R8
    event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_w != '0) |=> ((stat_w & $past(evt_w)) == $past(evt_w)));

    // R9
    no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_w & ~$past(stat_w) & ~$past(evt_w)) == '0);

    // R10
    unmapped_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && !mapped) |=> (rd_data_o == '0));

    for (genvar g = 0; g < LINES; g++) begin : g_rsv
        // R7
        reserved_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mode_w[g*MODE_W +: MODE_W] > 4'd4) |-> !evt_w[g]);
    end
endmodule

bind gpio_eint_ctrl eint_ctrl_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o),
    .evt_w     (evt_w),
    .mode_w    (mode_w),
    .en_w      (en_w),
    .stat_w    (stat_w)
);

// File: tb/gpio_eint_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_eint_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    gpio_eint_ctrl u_gpio_eint_ctrl (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .pin_i     (pins),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_en_i   (rd_en),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(posedge clk) rd_seen <= rd_en;
    initial begin
        forever begin
            @(negedge clk);
            if (rd_seen) begin
                if (exp_q.size() == 0) begin
                    check("scoreboard underflow", 32'h1, 32'h0);
                end else begin
                    check(tag_q.pop_front(), rd_data, exp_q.pop_front());
                end
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_exp(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        pins = v;
        idle(6);
    endtask

    localparam logic [11:0] A_EN = 12'h210;
    localparam logic [11:0] A_ST = 12'h214;

    bit finished = 1'b0;
    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd_exp(12'h200, 32'h0, "R1 cfg0");
        rd_exp(12'h204, 32'h0, "R1 cfg1");
        rd_exp(12'h208, 32'h0, "R1 cfg2");
        rd_exp(12'h20C, 32'h0, "R1 cfg3");
        rd_exp(A_EN, 32'h0, "R1 enable");
        rd_exp(A_ST, 32'h0, "R1 status");
        check("R1 irq", 32'(irq), 32'h0);

        // R2 readback
        wr(12'h208, 32'hA5A5A5A5);
        rd_exp(12'h208, 32'hA5A5A5A5, "R2 cfg2 readback");
        wr(A_EN, 32'hDEADBEEF);
        rd_exp(A_EN, 32'hDEADBEEF, "R2 enable readback");
        wr(A_EN, 32'h0);

        // R10 unmapped
        rd_exp(12'h100, 32'h0, "R10 read 0x100");
        rd_exp(12'h218, 32'h0, "R10 read 0x218");
        wr(12'h218, 32'hFFFFFFFF);
        rd_exp(A_EN, 32'h0, "R10 write 0x218 ignored enable");

        // baseline and configuration
        set_pins(32'h0000000A);
        wr(12'h200, 32'h9F543210);
        wr(12'h204, 32'h77777707);
        wr(12'h208, 32'h77777777);
        wr(12'h20C, 32'h77777777);
        wr(A_ST, 32'hFFFFFFFF);
        idle(2);
        rd_exp(A_ST, 32'h0, "R8 clear all");

        // R3 rising, R9 enable gating, R8 write zero
        set_pins(32'h0000000B);
        rd_exp(A_ST, 32'h1, "R3 rising sets");
        check("R9 irq low when disabled", 32'(irq), 32'h0);
        wr(A_ST, 32'h0);
        rd_exp(A_ST, 32'h1, "R8 write zero no effect");
        wr(A_EN, 32'h1);
        idle(3);
        check("R9 irq high when enabled", 32'(irq), 32'h1);
        wr(A_ST, 32'h1);
        idle(3);
        check("R9 irq low after clear", 32'(irq), 32'h0);
        rd_exp(A_ST, 32'h0, "R8 write one clears");
        set_pins(32'h0000000A);
        rd_exp(A_ST, 32'h0, "R3 falling ignored");
        wr(A_EN, 32'h0);

        // R4 falling
        set_pins(32'h00000008);
        rd_exp(A_ST, 32'h2, "R4 falling sets");
        wr(A_ST, 32'h2);
        set_pins(32'h0000000A);
        rd_exp(A_ST, 32'h0, "R4 rising ignored");

        // R5 both edges
        set_pins(32'h0000001A);
        rd_exp(A_ST, 32'h10, "R5 rise sets");
        wr(A_ST, 32'h10);
        set_pins(32'h0000000A);
        rd_exp(A_ST, 32'h10, "R5 fall sets");
        wr(A_ST, 32'h10);

        // R6 level modes
        set_pins(32'h0000000E);
        wr(A_ST, 32'h4);
        rd_exp(A_ST, 32'h4, "R6 high level survives clear");
        set_pins(32'h0000000A);
        wr(A_ST, 32'h4);
        rd_exp(A_ST, 32'h0, "R6 high level released");
        set_pins(32'h00000002);
        wr(A_ST, 32'h8);
        rd_exp(A_ST, 32'h8, "R6 low level survives clear");
        set_pins(32'h0000000A);
        wr(A_ST, 32'h8);
        rd_exp(A_ST, 32'h0, "R6 low level released");

        // R7 reserved modes
        set_pins(32'h000000EA);
        set_pins(32'h0000000A);
        rd_exp(A_ST, 32'h0, "R7 reserved quiet");

        // R2 field position of line 9
        set_pins(32'h0000020A);
        rd_exp(A_ST, 32'h200, "R2 line 9 field");
        wr(A_ST, 32'h200);
        set_pins(32'h0000000A);
        rd_exp(A_ST, 32'h0, "R2 line 9 rise only");

        // R8 event coincides with clear
        @(negedge clk);
        pins = 32'h0000020A;
        @(negedge clk);
        @(negedge clk);
        addr = A_ST; wr_data = 32'h200; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd_exp(A_ST, 32'h200, "R8 event wins over clear");
        wr(A_EN, 32'h200);
        idle(3);
        check("R9 irq from line 9", 32'(irq), 32'h1);

        idle(4);
        while (exp_q.size() != 0) @(negedge clk);
        finish_run();
    end
endmodule